// File: doc/BRIEF.md
# Variable-Resolution DAC Register Loader

This block sits behind a byte-serial register port and holds the setup and output codes for three DAC channels. Each frame opens with an address byte. A frame sent to the setup address carries one byte that picks, for every channel, whether it is driven and whether it takes an 8-bit or a 10-bit code. A frame sent to a channel address carries that channel's new code. The code is one byte long when the channel is in 8-bit mode and two bytes long when it is in 10-bit mode.

A channel's code register changes only once the whole code has arrived, so the DAC never sees a half-written 10-bit value. Codes are presented on a 10-bit bus per channel. An 8-bit code fills the upper eight bits, so both modes share the same full-scale span. A clear drive-enable flag marks a channel as powered down, and the pin it feeds is then held at high impedance. A second byte carrying stray upper bits raises a sticky format error flag.

Top module: `dac_reg_loader`

## Requirements
- R1: After reset every channel has drive enable 0 and 8-bit mode, every code is 0, and the format error flag is 0.
- R2: A frame whose address byte is 0xD3 writes the setup byte. Bits 7, 6 and 5 set 10-bit mode for channels 0, 1 and 2 (1 means 10-bit). Bits 3, 2 and 1 set drive enable for channels 0, 1 and 2. Bits 4 and 0 are ignored. The new setup shows on the outputs in the cycle after the byte is accepted.
- R3: A channel whose drive enable is 0 reports 0 on its drive_en_o bit, which marks the pin as high impedance, and its code register keeps its value.
- R4: In 8-bit mode, a frame whose address byte is 0xD4, 0xD5 or 0xD6 (channels 0, 1, 2) takes one data byte B. The channel code becomes B shifted left by 2, with code bits 1:0 equal to 0, in the cycle after B.
- R5: In 10-bit mode, such a frame takes two data bytes H and L. The code becomes H in bits 9:2 and L[1:0] in bits 1:0, and it changes only in the cycle after L.
- R6: A 10-bit write that ends (frame_end_i with its first data byte) before the second byte arrives leaves the code unchanged. The next byte after frame_end_i is treated as an address byte.
- R7: A second byte in 10-bit mode with any of bits 7:2 set makes fmt_err_o 1, and it stays 1 until reset. Bits 1:0 of that byte are still applied.
- R8: Bytes after the last byte a register needs, up to the end of the frame, are ignored. So is every byte of a frame whose address is not 0xD3 to 0xD6.
- R9: At most one channel code changes in any cycle, and a code changes only in the cycle after an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | byte_i carries a byte this cycle |
| byte_i | input | 8 | Serial register byte |
| frame_end_i | input | 1 | Current frame ends after this cycle; any byte in the same cycle is its last |
| code_o | output | 30 | Channel codes, channel n in bits 10n+9:10n |
| drive_en_o | output | 3 | Per-channel drive enable; 0 means high impedance |
| wide_o | output | 3 | Per-channel 10-bit mode flag |
| fmt_err_o | output | 1 | Sticky malformed second byte flag |

## Verification
The checks assume that register state moves only in response to an accepted byte. They also assume that a setup change never lands in the same cycle as a code update, which holds because every frame addresses exactly one register. The stimulus drives inputs only between clock edges and sends whole frames separated by idle cycles. It marks the end of each frame with frame_end_i on the final byte, so no frame is left open when a new address is expected. It also covers frames cut short, frames padded with surplus bytes, unknown addresses and malformed low bytes. A behavioural model tracks every output and is compared on each cycle.

// File: rtl/dac_ldr_pkg.sv
package dac_ldr_pkg;
  typedef enum logic [2:0] {
    ST_ADDR  = 3'd0,
    ST_SETUP = 3'd1,
    ST_DATA0 = 3'd2,
    ST_DATA1 = 3'd3,
    ST_SKIP  = 3'd4
  } ldr_state_t;
endpackage

// File: rtl/dac_frame_parser.sv
module dac_frame_parser
  import dac_ldr_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter int          HI_W      = 10,
  parameter int          LO_W      = 8,
  parameter logic [7:0]  SETUP_ADR = 8'hD3,
  parameter logic [7:0]  DATA_BASE = 8'hD4,
  localparam int         CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int         EXT_W     = HI_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [LO_W-1:0]   byte_i,
  input  logic              frame_end_i,
  input  logic [NUM_CH-1:0] wide_i,
  output logic              setup_we_o,
  output logic              code_we_o,
  output logic [CH_W-1:0]   code_ch_o,
  output logic [HI_W-1:0]   code_val_o,
  output logic              fmt_err_o
);
  ldr_state_t      state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [LO_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] offs;
  logic            is_data;

  assign offs    = byte_i - LO_W'(DATA_BASE);
  assign is_data = (byte_i >= LO_W'(DATA_BASE)) && (offs < LO_W'(NUM_CH));

  always_comb begin
    state_d    = state_q;
    ch_d       = ch_q;
    hi_d       = hi_q;
    setup_we_o = 1'b0;
    code_we_o  = 1'b0;
    code_val_o = '0;
    fmt_err_o  = 1'b0;
    if (byte_vld_i) begin
      unique case (state_q)
        ST_ADDR: begin
          if (byte_i == LO_W'(SETUP_ADR)) state_d = ST_SETUP;
          else if (is_data) begin
            state_d = ST_DATA0;
            ch_d    = offs[CH_W-1:0];
          end else state_d = ST_SKIP;
        end
        ST_SETUP: begin
          setup_we_o = 1'b1;
          state_d    = ST_SKIP;
        end
        ST_DATA0: begin
          if (wide_i[ch_q]) begin
            hi_d    = byte_i;
            state_d = ST_DATA1;
          end else begin
            code_we_o  = 1'b1;
            code_val_o = {byte_i, {EXT_W{1'b0}}};
            state_d    = ST_SKIP;
          end
        end
        ST_DATA1: begin
          code_we_o  = 1'b1;
          code_val_o = {hi_q, byte_i[EXT_W-1:0]};
          fmt_err_o  = |byte_i[LO_W-1:EXT_W];
          state_d    = ST_SKIP;
        end
        default: state_d = ST_SKIP;
      endcase
    end
    if (frame_end_i) state_d = ST_ADDR;
  end

  assign code_ch_o = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ADDR;
      ch_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      hi_q    <= hi_d;
    end
  end
endmodule

// File: rtl/dac_setup_reg.sv
module dac_setup_reg #(
  parameter int  NUM_CH = 3,
  parameter int  LO_W   = 8,
  localparam int RES_TOP = LO_W - 1,
  localparam int EN_TOP  = LO_W / 2 - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LO_W-1:0]   byte_i,
  output logic [NUM_CH-1:0] wide_o,
  output logic [NUM_CH-1:0] drive_en_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wide_o[i]     <= 1'b0;
        drive_en_o[i] <= 1'b0;
      end else if (we_i) begin
        wide_o[i]     <= byte_i[RES_TOP-i];
        drive_en_o[i] <= byte_i[EN_TOP-i];
      end
    end
  end
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank #(
  parameter int  NUM_CH = 3,
  parameter int  HI_W   = 10,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [CH_W-1:0]        ch_i,
  input  logic [HI_W-1:0]        val_i,
  output logic [NUM_CH*HI_W-1:0] code_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_o[i*HI_W +: HI_W] <= '0;
      else if (we_i && ch_i == CH_W'(i)) code_o[i*HI_W +: HI_W] <= val_i;
    end
  end
endmodule

// File: rtl/dac_reg_loader.sv
module dac_reg_loader #(
  parameter int         NUM_CH    = 3,
  parameter int         HI_W      = 10,
  parameter int         LO_W      = 8,
  parameter logic [7:0] SETUP_ADR = 8'hD3,
  parameter logic [7:0] DATA_BASE = 8'hD4,
  localparam int        CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   byte_vld_i,
  input  logic [LO_W-1:0]        byte_i,
  input  logic                   frame_end_i,
  output logic [NUM_CH*HI_W-1:0] code_o,
  output logic [NUM_CH-1:0]      drive_en_o,
  output logic [NUM_CH-1:0]      wide_o,
  output logic                   fmt_err_o
);
  logic            setup_we, code_we, err_hit;
  logic [CH_W-1:0] code_ch;
  logic [HI_W-1:0] code_val;

  dac_frame_parser #(
    .NUM_CH(NUM_CH), .HI_W(HI_W), .LO_W(LO_W),
    .SETUP_ADR(SETUP_ADR), .DATA_BASE(DATA_BASE)
  ) u_parser (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .frame_end_i(frame_end_i), .wide_i(wide_o), .setup_we_o(setup_we),
    .code_we_o(code_we), .code_ch_o(code_ch), .code_val_o(code_val),
    .fmt_err_o(err_hit)
  );

  dac_setup_reg #(.NUM_CH(NUM_CH), .LO_W(LO_W)) u_setup (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(setup_we), .byte_i(byte_i),
    .wide_o(wide_o), .drive_en_o(drive_en_o)
  );

  dac_code_bank #(.NUM_CH(NUM_CH), .HI_W(HI_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(code_we), .ch_i(code_ch),
    .val_i(code_val), .code_o(code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fmt_err_o <= 1'b0;
    else if (err_hit) fmt_err_o <= 1'b1;
  end
endmodule

// File: rtl/dac_reg_loader_chk.sv
module dac_reg_loader_chk #(
  parameter int  NUM_CH = 3,
  parameter int  HI_W   = 10,
  parameter int  LO_W   = 8,
  localparam int EXT_W  = HI_W - LO_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   byte_vld_i,
  input logic [LO_W-1:0]        byte_i,
  input logic [NUM_CH*HI_W-1:0] code_o,
  input logic [NUM_CH-1:0]      drive_en_o,
  input logic [NUM_CH-1:0]      wide_o,
  input logic                   fmt_err_o
);
  logic [NUM_CH*HI_W-1:0] prev_code;
  logic [NUM_CH-1:0]      chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_code <= '0;
    else         prev_code <= code_o;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign chg[i] = code_o[i*HI_W +: HI_W] != prev_code[i*HI_W +: HI_W];

    assert_narrow_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chg[i] && !wide_o[i]) |-> code_o[i*HI_W +: EXT_W] == '0);
  end

  assert_one_channel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chg) <= 1);

  assert_code_needs_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> $past(byte_vld_i));

  assert_setup_needs_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({drive_en_o, wide_o}) |-> $past(byte_vld_i));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |=> fmt_err_o);

  assert_err_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fmt_err_o) |-> $past(byte_vld_i && (byte_i[LO_W-1:EXT_W] != '0)));
endmodule

bind dac_reg_loader dac_reg_loader_chk #(.NUM_CH(NUM_CH), .HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
  .code_o(code_o), .drive_en_o(drive_en_o), .wide_o(wide_o), .fmt_err_o(fmt_err_o)
);

// File: tb/dac_reg_loader_tb.sv
module dac_reg_loader_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        frame_end_i = 1'b0;
  logic [29:0] code_o;
  logic [2:0]  drive_en_o, wide_o;
  logic        fmt_err_o;

  dac_reg_loader u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .frame_end_i(frame_end_i), .code_o(code_o), .drive_en_o(drive_en_o),
    .wide_o(wide_o), .fmt_err_o(fmt_err_o)
  );

  always #5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";
  int m_code[3];
  bit m_en[3], m_wide[3];
  bit m_err = 0;
  int m_phase = 0, m_ch = 0, m_hi = 0;
  logic [7:0] fq[$];

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    for (int i = 0; i < 3; i++) begin
      check(req, $sformatf("code ch%0d", i), int'(code_o[i*10 +: 10]), m_code[i]);
      check(req, $sformatf("drive_en ch%0d", i), int'(drive_en_o[i]), int'(m_en[i]));
      check(req, $sformatf("wide ch%0d", i), int'(wide_o[i]), int'(m_wide[i]));
    end
    check(req, "fmt_err", int'(fmt_err_o), int'(m_err));
  endtask

  // behavioural model of one accepted byte
  task automatic model_byte(int b, bit last);
    case (m_phase)
      0: begin
        if (b == 'hD3) m_phase = 1;
        else if (b >= 'hD4 && b <= 'hD6) begin m_ch = b - 'hD4; m_phase = 2; end
        else m_phase = 4;
      end
      1: begin
        for (int i = 0; i < 3; i++) begin
          m_wide[i] = b[7-i];
          m_en[i]   = b[3-i];
        end
        m_phase = 4;
      end
      2: begin
        if (m_wide[m_ch]) begin m_hi = b; m_phase = 3; end
        else begin m_code[m_ch] = b * 4; m_phase = 4; end
      end
      3: begin
        m_code[m_ch] = m_hi * 4 + (b % 4);
        if (b / 4 != 0) m_err = 1;
        m_phase = 4;
      end
      default: ;
    endcase
    if (last) m_phase = 0;
  endtask

  task automatic send_frame(bit cut_end);
    for (int k = 0; k < fq.size(); k++) begin
      @(negedge clk_i);
      byte_vld_i  = 1'b1;
      byte_i      = fq[k];
      frame_end_i = (k == fq.size() - 1) && cut_end;
      @(posedge clk_i);
      #1 model_byte(int'(fq[k]), (k == fq.size() - 1) && cut_end);
    end
    @(negedge clk_i);
    byte_vld_i  = 1'b0;
    frame_end_i = 1'b0;
    @(negedge clk_i);
  endtask

  always @(negedge clk_i) if (rst_ni && !done) compare_all(cur_req);

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_code[i] = 0; m_en[i] = 0; m_wide[i] = 0; end
    repeat (3) @(negedge clk_i);
    compare_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "reset codes", int'(code_o), 0);
    check("R1", "reset enables", int'(drive_en_o), 0);

    // R2: reserved bits 4 and 0 set, ch1 wide, all enabled
    cur_req = "R2";
    fq = '{8'hD3, 8'h5F}; send_frame(1);
    check("R2", "wide_o", int'(wide_o), 3'b010);
    check("R2", "drive_en_o", int'(drive_en_o), 3'b111);

    cur_req = "R4";
    fq = '{8'hD4, 8'hA5}; send_frame(1);
    check("R4", "ch0 narrow code", int'(code_o[9:0]), 'h294);

    // R5: code must hold after the first byte, update after the second
    cur_req = "R5";
    @(negedge clk_i); byte_vld_i = 1; byte_i = 8'hD5;
    @(posedge clk_i); #1 model_byte('hD5, 0);
    @(negedge clk_i); byte_i = 8'h3C;
    @(posedge clk_i); #1 model_byte('h3C, 0);
    @(negedge clk_i); byte_vld_i = 0;
    check("R5", "ch1 after first byte", int'(code_o[19:10]), 0);
    @(negedge clk_i); byte_vld_i = 1; byte_i = 8'h02; frame_end_i = 1;
    @(posedge clk_i); #1 model_byte('h02, 1);
    @(negedge clk_i); byte_vld_i = 0; frame_end_i = 0;
    check("R5", "ch1 wide code", int'(code_o[19:10]), 'hF2);

    cur_req = "R6";
    fq = '{8'hD5, 8'h77}; send_frame(1);
    check("R6", "ch1 after cut write", int'(code_o[19:10]), 'hF2);
    fq = '{8'hD6, 8'h99}; send_frame(1);
    check("R6", "ch2 next frame addressed", int'(code_o[29:20]), 'h264);

    cur_req = "R7";
    check("R7", "err clear before", int'(fmt_err_o), 0);
    fq = '{8'hD5, 8'h81, 8'hFD}; send_frame(1);
    check("R7", "ch1 low bits applied", int'(code_o[19:10]), 'h205);
    check("R7", "err set", int'(fmt_err_o), 1);
    fq = '{8'hD5, 8'h10, 8'h03}; send_frame(1);
    check("R7", "err sticky", int'(fmt_err_o), 1);

    cur_req = "R8";
    fq = '{8'hD4, 8'h11, 8'h22, 8'h33}; send_frame(1);
    check("R8", "ch0 surplus ignored", int'(code_o[9:0]), 'h44);
    fq = '{8'hD0, 8'h55, 8'h00}; send_frame(1);
    check("R8", "unknown addr codes", int'(code_o[9:0]), 'h44);
    check("R8", "unknown addr setup", int'(drive_en_o), 3'b111);

    cur_req = "R3";
    fq = '{8'hD3, 8'h44}; send_frame(1);
    check("R3", "only ch1 driven", int'(drive_en_o), 3'b010);
    check("R3", "ch0 code held", int'(code_o[9:0]), 'h44);
    fq = '{8'hD4, 8'h01}; send_frame(1);
    check("R3", "disabled ch0 still loads", int'(code_o[9:0]), 'h4);

    cur_req = "R9";
    fq = '{8'hD3, 8'hEE}; send_frame(1);
    fq = '{8'hD6, 8'hFF, 8'h03}; send_frame(1);
    check("R9", "ch2 wide full scale", int'(code_o[29:20]), 'h3FF);
    check("R9", "ch1 untouched", int'(code_o[19:10]), 'h43);

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule